// File: doc/BRIEF.md
# Address-Routed Packet Router

This block takes a byte stream of packets on a single 8-bit input and sorts each packet into one of four output queues. The first byte of a packet names its destination and the second gives its payload length. The payload bytes follow, and a check byte closes the packet. The destination is compared against four port addresses supplied on input pins. A matching packet is written into that port's queue. It becomes visible to the port's reader only after its check byte has been verified, so the block works store-and-forward. A packet with a bad check byte is removed from the queue again and an error pulse is raised. A packet whose destination matches no port is read in and thrown away.

The input uses `in_valid` together with `in_suspend`, which is the inverse of a ready signal. A byte is taken on a rising edge where `in_valid` is high and `in_suspend` is low. While `in_suspend` is high the sender must hold the byte and keep `in_valid` high. Suspend can only be raised while the length byte is on the input. At that point it depends on the presented byte, because the block reserves space for the whole packet body in one step. Each output is a valid/ready stream. A queue entry leaves when `out_valid[i]` and `out_ready[i]` are both high. An output whose valid is high keeps its data steady until it is read. The queue depth must be a power of two and at least 64.

Top module: `pkt_router`

## Requirements
- R1: After a synchronous reset, every `out_valid` bit, `in_suspend` and `err` are low.
- R2: A packet is laid out as destination byte, then length byte, then N payload bytes, then one check byte. N is the low 6 bits of the length byte (0 to 63), and the upper two bits do not affect the count. The selected output delivers the length byte unchanged, followed by the N payload bytes in arrival order. The destination and check bytes are not delivered.
- R3: A packet goes to the lowest-numbered port whose address (port i at `port_addr[8i+7:8i]`) equals the destination byte. No other output raises valid for it.
- R4: The check byte must equal the XOR of the destination, length and payload bytes. On a mismatch, `err` is high for exactly one cycle, in the cycle just after the check byte is taken, and no byte of that packet ever appears on an output.
- R5: A packet that matches no port is taken in full, reaches no output and raises no error. The packet after it is handled normally.
- R6: A port's `out_valid` stays low while a packet for that empty port is being received. It rises in the cycle just after the packet's valid check byte is taken.
- R7: While the length byte is presented, `in_suspend` is high exactly when the target queue has fewer free entries than N+1. It is low in every other phase, and also for packets that match no port. Each queue holds 64 entries.
- R8: While `out_valid[i]` is high and `out_ready[i]` is low, the valid bit and `out_data` for that port hold their values.
- R9: Packets for the same port come out in arrival order. A queue can hold several packets, and ports drain independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_addr | input | 32 | Port addresses, port i in bits 8i+7:8i |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_suspend | output | 1 | Input stalled; byte not taken while high |
| err | output | 1 | One-cycle pulse on check-byte mismatch |
| out_valid | output | 4 | Per-port queue holds a verified byte |
| out_ready | input | 4 | Per-port read enable |
| out_data | output | 32 | Per-port head byte, port i in bits 8i+7:8i |

## Verification
The hardest state to reach is the suspend condition. It needs a queue almost full with committed data while a new packet for the same port arrives with its length byte held on the input. The bench first sends a maximum-length packet to one port, which fills its 64 entries. It then presents a second header for that port and holds the length byte while removing entries one at a time. It checks that suspend stays high until exactly N+1 entries are free, and that the held byte is then taken once.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
  typedef enum logic [1:0] {
    ST_DEST  = 2'd0,
    ST_LEN   = 2'd1,
    ST_BODY  = 2'd2,
    ST_CHECK = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pkt_fifo.sv
// Output queue with a tentative write pointer: bytes of a packet in
// flight are invisible to the reader until commit, and rewind drops them.
module pkt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rewind,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [PW-1:0] free_cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic [PW-1:0] used, cm_used;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (rewind)     wr_ptr <= cm_ptr;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (commit)     cm_ptr <= wr_ptr;
      if (rd_en)      rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign used     = wr_ptr - rd_ptr;
  assign cm_used  = cm_ptr - rd_ptr;
  assign full     = (used == PW'(DEPTH));
  assign free_cnt = PW'(DEPTH) - used;
  assign empty    = (cm_ptr == rd_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  assert_commit_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    cm_used <= used);
endmodule

// File: rtl/pkt_addr_match.sv
// Destination decode: lowest-indexed port with an equal address wins.
module pkt_addr_match #(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [DW-1:0]       dest,
  input  logic [NPORT*DW-1:0] port_addr,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (port_addr[i*DW +: DW] == dest) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pkt_rx_ctrl.sv
// Receive FSM: header parse, space reservation, check-byte verify.
module pkt_rx_ctrl
  import pkt_router_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  parameter int LENW  = 6,
  parameter int PW    = 7,
  localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             hit,
  input  logic [IW-1:0]    idx,
  input  logic [PW-1:0]    free_cnt [NPORT],
  output logic             in_suspend,
  output logic [NPORT-1:0] wr_en,
  output logic [DW-1:0]    wr_data,
  output logic [NPORT-1:0] commit,
  output logic [NPORT-1:0] rewind,
  output logic             err
);
  rx_state_e       state;
  logic [IW-1:0]   tgt;
  logic            tgt_hit;
  logic [DW-1:0]   chk;
  logic [LENW-1:0] remain;
  logic [LENW-1:0] len_in;
  logic [PW-1:0]   need;
  logic            accept;

  assign len_in     = in_data[LENW-1:0];
  assign need       = PW'(len_in) + PW'(1);
  assign in_suspend = (state == ST_LEN) && tgt_hit && (free_cnt[tgt] < need);
  assign accept     = in_valid && !in_suspend;
  assign wr_data    = in_data;

  always_comb begin
    wr_en  = '0;
    commit = '0;
    rewind = '0;
    if (accept && tgt_hit) begin
      if (state == ST_LEN || state == ST_BODY) wr_en[tgt] = 1'b1;
      if (state == ST_CHECK) begin
        if (chk == in_data) commit[tgt] = 1'b1;
        else                rewind[tgt] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_DEST;
      tgt     <= '0;
      tgt_hit <= 1'b0;
      chk     <= '0;
      remain  <= '0;
      err     <= 1'b0;
    end else begin
      err <= 1'b0;
      if (accept) begin
        unique case (state)
          ST_DEST: begin
            tgt     <= idx;
            tgt_hit <= hit;
            chk     <= in_data;
            state   <= ST_LEN;
          end
          ST_LEN: begin
            chk    <= chk ^ in_data;
            remain <= len_in;
            state  <= (len_in == '0) ? ST_CHECK : ST_BODY;
          end
          ST_BODY: begin
            chk    <= chk ^ in_data;
            remain <= remain - 1'b1;
            if (remain == LENW'(1)) state <= ST_CHECK;
          end
          ST_CHECK: begin
            err   <= (chk != in_data);
            state <= ST_DEST;
          end
          default: state <= ST_DEST;
        endcase
      end
    end
  end

  assert_err_single_R4: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  assert_wr_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  assert_commit_rewind_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(commit) + $countones(rewind) <= 1);
endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import pkt_router_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int LENW  = 6,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT*DW-1:0] port_addr,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_data,
  output logic                in_suspend,
  output logic                err,
  output logic [NPORT-1:0]    out_valid,
  input  logic [NPORT-1:0]    out_ready,
  output logic [NPORT*DW-1:0] out_data
);
  logic             m_hit;
  logic [IW-1:0]    m_idx;
  logic [PW-1:0]    free_cnt [NPORT];
  logic [NPORT-1:0] wr_en, commit, rewind, q_empty, q_full, pop;
  logic [DW-1:0]    wr_data;

  pkt_addr_match #(.NPORT(NPORT), .DW(DW)) u_match (
    .dest(in_data), .port_addr(port_addr), .hit(m_hit), .idx(m_idx)
  );

  pkt_rx_ctrl #(.NPORT(NPORT), .DW(DW), .LENW(LENW), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .hit(m_hit), .idx(m_idx), .free_cnt(free_cnt),
    .in_suspend(in_suspend), .wr_en(wr_en), .wr_data(wr_data),
    .commit(commit), .rewind(rewind), .err(err)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pkt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[g]), .wr_data(wr_data),
      .commit(commit[g]), .rewind(rewind[g]),
      .rd_en(pop[g]), .rd_data(out_data[g*DW +: DW]),
      .empty(q_empty[g]), .full(q_full[g]), .free_cnt(free_cnt[g])
    );
    assign out_valid[g] = ~q_empty[g];
    assign pop[g]       = out_valid[g] & out_ready[g];

    assert_hold_valid_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && !out_ready[g]) |=> out_valid[g]);
    assert_hold_data_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && !out_ready[g]) |=> $stable(out_data[g*DW +: DW]));
  end
endmodule

// File: tb/pkt_router_bench.sv
module pkt_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] port_addr;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_suspend, err;
  logic [3:0]  out_valid;
  logic [3:0]  out_ready = 4'h0;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_router u_pkt_router (
    .clk(clk), .rst(rst), .port_addr(port_addr),
    .in_valid(in_valid), .in_data(in_data), .in_suspend(in_suspend),
    .err(err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (in_suspend) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_rest(input logic [7:0] da, input logic [7:0] lenb,
                           input logic [7:0] seed, input bit bad, input int watch);
    logic [7:0] x;
    x = da ^ lenb;
    send_byte(lenb);
    for (int i = 0; i < int'(lenb[5:0]); i++) begin
      x ^= pay(seed, i);
      send_byte(pay(seed, i));
    end
    if (watch >= 0) chk(out_valid[watch] == 1'b0, "R6 valid before check", 32'(out_valid[watch]), 0);
    send_byte(bad ? ~x : x);
    chk(err == bad, "R4 err after check byte", 32'(err), 32'(bad));
    @(posedge clk);
    #1;
    chk(err == 1'b0, "R4 err one cycle", 32'(err), 0);
  endtask

  task automatic send_pkt(input logic [7:0] da, input logic [7:0] lenb,
                          input logic [7:0] seed, input bit bad, input int watch);
    send_byte(da);
    send_rest(da, lenb, seed, bad, watch);
  endtask

  task automatic pop_expect(input int p, input logic [7:0] exp, input string req);
    @(negedge clk);
    out_ready[p] = 1'b1;
    #1;
    chk(out_valid[p] == 1'b1, req, 32'(out_valid[p]), 1);
    chk(out_data[p*8 +: 8] == exp, req, 32'(out_data[p*8 +: 8]), 32'(exp));
    @(posedge clk);
    #1;
    out_ready[p] = 1'b0;
  endtask

  task automatic drain_pkt(input int p, input logic [7:0] lenb, input logic [7:0] seed,
                           input string req);
    pop_expect(p, lenb, req);
    for (int i = 0; i < int'(lenb[5:0]); i++) pop_expect(p, pay(seed, i), req);
  endtask

  task automatic t_reset;
    chk(out_valid == 4'h0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_suspend == 1'b0, "R1 in_suspend", 32'(in_suspend), 0);
    chk(err == 1'b0, "R1 err", 32'(err), 0);
  endtask

  task automatic t_route;
    send_pkt(8'hF9, 8'd3, 8'h11, 1'b0, 1);
    chk(out_valid == 4'b0010, "R3 F9 to port1 only", 32'(out_valid), 32'h2);
    drain_pkt(1, 8'd3, 8'h11, "R2 port1 contents");
    send_pkt(8'hF8, 8'd2, 8'h40, 1'b0, 0);
    chk(out_valid == 4'b0001, "R3 F8 to port0 only", 32'(out_valid), 32'h1);
    drain_pkt(0, 8'd2, 8'h40, "R2 port0 contents");
    chk(out_valid == 4'h0, "R2 nothing extra", 32'(out_valid), 0);
  endtask

  task automatic t_lengths;
    send_pkt(8'h10, 8'h00, 8'h00, 1'b0, 2);
    chk(out_valid == 4'b0100, "R2 zero length stored", 32'(out_valid), 32'h4);
    drain_pkt(2, 8'h00, 8'h00, "R2 zero length");
    chk(out_valid == 4'h0, "R2 zero length one entry", 32'(out_valid), 0);
    send_pkt(8'h20, 8'hC2, 8'h5A, 1'b0, 3);
    drain_pkt(3, 8'hC2, 8'h5A, "R2 upper length bits ignored");
    chk(out_valid == 4'h0, "R2 upper bits count", 32'(out_valid), 0);
  endtask

  task automatic t_bad_check;
    send_pkt(8'hF9, 8'd4, 8'h23, 1'b1, 1);
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 4'h0, "R4 bad packet discarded", 32'(out_valid), 0);
    send_pkt(8'hF9, 8'd1, 8'h77, 1'b0, 1);
    drain_pkt(1, 8'd1, 8'h77, "R4 queue clean after discard");
  endtask

  task automatic t_no_match;
    send_pkt(8'h55, 8'd3, 8'h31, 1'b0, -1);
    chk(out_valid == 4'h0, "R5 unmatched dropped", 32'(out_valid), 0);
    send_pkt(8'hF8, 8'd1, 8'h09, 1'b0, 0);
    drain_pkt(0, 8'd1, 8'h09, "R5 next packet intact");
  endtask

  task automatic t_priority;
    port_addr[23:16] = 8'hF8;
    send_pkt(8'hF8, 8'd2, 8'h66, 1'b0, 0);
    chk(out_valid == 4'b0001, "R3 lowest index wins", 32'(out_valid), 32'h1);
    drain_pkt(0, 8'd2, 8'h66, "R3 priority contents");
    port_addr[23:16] = 8'h10;
  endtask

  task automatic t_hold;
    send_pkt(8'h20, 8'd2, 8'h90, 1'b0, 3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid[3] == 1'b1, "R8 valid held", 32'(out_valid[3]), 1);
      chk(out_data[31:24] == 8'd2, "R8 data held", 32'(out_data[31:24]), 2);
    end
    drain_pkt(3, 8'd2, 8'h90, "R8 contents after hold");
  endtask

  task automatic t_queue;
    send_pkt(8'h10, 8'd3, 8'hA0, 1'b0, 2);
    send_pkt(8'hF9, 8'd2, 8'hB0, 1'b0, 1);
    send_pkt(8'h10, 8'd4, 8'hC0, 1'b0, -1);
    chk(out_valid == 4'b0110, "R9 two ports pending", 32'(out_valid), 32'h6);
    drain_pkt(2, 8'd3, 8'hA0, "R9 first packet first");
    drain_pkt(1, 8'd2, 8'hB0, "R9 other port");
    drain_pkt(2, 8'd4, 8'hC0, "R9 second packet second");
    chk(out_valid == 4'h0, "R9 all drained", 32'(out_valid), 0);
  endtask

  task automatic t_suspend;
    send_pkt(8'hF8, 8'd63, 8'h01, 1'b0, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hF8;
    #1;
    chk(in_suspend == 1'b0, "R7 no suspend on destination", 32'(in_suspend), 0);
    @(posedge clk);
    #1;
    @(negedge clk);
    in_data = 8'd5;
    #1;
    chk(in_suspend == 1'b1, "R7 suspend when full", 32'(in_suspend), 1);
    pop_expect(0, 8'd63, "R7 drain head");
    for (int i = 0; i < 4; i++) pop_expect(0, pay(8'h01, i), "R7 drain");
    chk(in_suspend == 1'b1, "R7 suspend at five free", 32'(in_suspend), 1);
    pop_expect(0, pay(8'h01, 4), "R7 drain");
    chk(in_suspend == 1'b0, "R7 release at six free", 32'(in_suspend), 0);
    send_rest(8'hF8, 8'd5, 8'h80, 1'b0, -1);
    for (int i = 5; i < 63; i++) pop_expect(0, pay(8'h01, i), "R7 first packet tail");
    drain_pkt(0, 8'd5, 8'h80, "R7 held packet");
    chk(out_valid == 4'h0, "R7 exact drain", 32'(out_valid), 0);
  endtask

  initial begin
    port_addr = {8'h20, 8'h10, 8'hF9, 8'hF8};
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_route();
    t_lengths();
    t_bad_check();
    t_no_match();
    t_priority();
    t_hold();
    t_queue();
    t_suspend();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule